// File: doc/BRIEF.md
# Ping-Pong Buffered Burst Writer

This block takes a continuous stream of acquired samples and places it in external memory through a memory controller's local write port. Two internal sample banks take turns. The stream fills one bank while the other bank is copied out to memory. When a bank holds a full load, the sequencer asks the controller for one burst whose length equals the bank depth. It streams every word of that bank, waits until the bank reports empty, and then waits for the other bank to become full.

Writing continues until a fixed number of bursts has been stored. The sequencer then parks in its idle state and stores nothing more until the host has read the memory out and pulses a clear. The clear rewinds the write address and the burst count and empties both banks. The sequencer steps through five states: idle, wait-for-full, request, drain and wait-for-empty.

The sample input offers no back-pressure, because an acquisition source cannot stall. `s_ready` only reports whether a sample presented in that cycle will be stored; a sample offered while `s_ready` is low is lost. On the memory side, a request and each write beat are held stable until the controller raises `mem_ready`.

Top module: `pingpong_burst_writer`

## Requirements
- R1: After reset, `mem_req`, `mem_wvalid`, `cap_reached`, `overflow` and `s_ready` are low and `mem_addr` is 0.
- R2: Accepted samples reach memory in arrival order. Bank 0 is filled first, then bank 1, and so on alternately, each bank taking FIFO_DEPTH samples before the fill moves to the other bank.
- R3: Once the bank being waited on is full, `mem_req` rises with `mem_burst` equal to FIFO_DEPTH and `mem_addr` equal to the next free word address. `mem_req` stays high until a cycle with `mem_ready` high.
- R4: Each burst has exactly FIFO_DEPTH beats on `mem_wvalid`. A beat is taken only in a cycle with `mem_ready` high. `mem_wdata` and `mem_addr` hold while `mem_ready` is low, and `mem_addr` rises by one per taken beat.
- R5: After its last beat, the sequencer waits for the drained bank to be empty, then waits for the other bank to fill. Consecutive bursts come from alternate banks.
- R6: After CAP_BURSTS bursts, `cap_reached` goes high and no further request or beat is issued. `s_ready` stays low and incoming samples are discarded without setting `overflow`.
- R7: A sample arriving while acquisition is running, the fill bank is full and the other bank is still full or being drained is discarded (`s_ready` low) and sets `overflow`. `overflow` stays set until a clear.
- R8: A `host_clear` pulse empties both banks and zeroes `mem_addr`, the burst count, `cap_reached` and `overflow`. The sequencer resumes waiting for a full bank if `acq_en` is high, and idles otherwise.
- R9: While `acq_en` is low and the sequencer is idle, `s_ready` is low and samples are discarded without effect on memory or `overflow`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_en | input | 1 | Acquisition enable |
| host_clear | input | 1 | Host pulse after read-out: rewinds address and count |
| s_valid | input | 1 | Sample present this cycle |
| s_data | input | DATA_W | Sample value |
| s_ready | output | 1 | Sample presented this cycle is stored |
| mem_req | output | 1 | Burst request to memory controller |
| mem_burst | output | $clog2(FIFO_DEPTH+1) | Burst length in words |
| mem_wvalid | output | 1 | Write beat valid |
| mem_wdata | output | DATA_W | Write beat data |
| mem_addr | output | ADDR_W | Burst start address during request, beat address during drain |
| mem_ready | input | 1 | Controller accepts request or beat |
| cap_reached | output | 1 | Capacity stored, storage frozen |
| overflow | output | 1 | Sticky: a sample was lost to full banks |

## Verification
The bench builds the block with 8-bit samples, banks four deep, a capacity of three bursts and a 6-bit address. A whole capacity run therefore takes only twelve samples, so a full stop, a clear and a fresh run from address zero all fit in a short test. The shallow banks let both of them fill behind a stalled request after nine back-to-back samples, which produces an overflow. An alternating ready pattern exercises beat holding on every other cycle.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_FULL,
    ST_REQ_BURST,
    ST_DRAIN,
    ST_WAIT_EMPTY
  } seq_state_t;
endpackage

// File: rtl/pbw_bank.sv
module pbw_bank #(
  parameter int DATA_W = 12,
  parameter int DEPTH  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              full,
  output logic              empty,
  output logic              one_left
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

  logic [DATA_W-1:0] store [DEPTH];
  logic [PW-1:0]     wp, rp;
  logic [CW-1:0]     cnt;

  assign full     = (cnt == CW'(DEPTH));
  assign empty    = (cnt == '0);
  assign one_left = (cnt == CW'(DEPTH - 1));
  assign rd_data  = store[rp];

  always_ff @(posedge clk) begin
    if (wr_en) store[wp] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (wr_en) wp <= (wp == LAST) ? '0 : wp + 1'b1;
      if (rd_en) rp <= (rp == LAST) ? '0 : rp + 1'b1;
      case ({wr_en, rd_en})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty); // R4
  AST_NO_PUSH_FULL: assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full); // R7
endmodule

// File: rtl/pbw_fill.sv
module pbw_fill (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       s_valid,
  input  logic       capture_on,
  input  logic [1:0] bank_full,
  input  logic [1:0] bank_one_left,
  input  logic       drain_busy,
  input  logic       drain_sel,
  output logic [1:0] wr_en,
  output logic       s_ready,
  output logic       overflow
);
  logic fill_sel;
  logic blocked;

  assign blocked = bank_full[fill_sel] || (drain_busy && (drain_sel == fill_sel));
  assign s_ready = capture_on && !blocked;

  for (genvar b = 0; b < 2; b++) begin : g_wr
    assign wr_en[b] = s_valid && s_ready && (fill_sel == 1'(b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      fill_sel <= 1'b0;
      overflow <= 1'b0;
    end else begin
      if (s_valid && s_ready && bank_one_left[fill_sel]) fill_sel <= ~fill_sel;
      if (s_valid && capture_on && blocked) overflow <= 1'b1;
    end
  end

  AST_FILL_NOT_DRAINING: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_busy && (wr_en != 2'b00)) |-> !wr_en[drain_sel]); // R2
endmodule

// File: rtl/pbw_seq.sv
module pbw_seq
  import pbw_pkg::*;
#(
  parameter int DEPTH      = 16,
  parameter int CAP_BURSTS = 8,
  parameter int ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acq_en,
  input  logic              host_clear,
  input  logic [1:0]        bank_full,
  input  logic [1:0]        bank_empty,
  input  logic              mem_ready,
  output logic              mem_req,
  output logic              mem_wvalid,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [1:0]        rd_en,
  output logic              drain_sel,
  output logic              drain_busy,
  output logic              capture_on,
  output logic              cap_reached
);
  localparam int BTW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CTW = $clog2(CAP_BURSTS + 1);

  seq_state_t        state;
  logic [BTW-1:0]    beat_cnt;
  logic [CTW-1:0]    burst_cnt;
  logic [ADDR_W-1:0] addr;
  logic              done;

  assign mem_req     = (state == ST_REQ_BURST);
  assign mem_wvalid  = (state == ST_DRAIN);
  assign mem_addr    = addr;
  assign drain_busy  = (state == ST_REQ_BURST) || (state == ST_DRAIN) || (state == ST_WAIT_EMPTY);
  assign capture_on  = acq_en && (state != ST_IDLE) && !done;
  assign cap_reached = done;

  for (genvar b = 0; b < 2; b++) begin : g_rd
    assign rd_en[b] = mem_wvalid && mem_ready && (drain_sel == 1'(b));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      beat_cnt  <= '0;
      burst_cnt <= '0;
      addr      <= '0;
      drain_sel <= 1'b0;
      done      <= 1'b0;
    end else if (host_clear) begin
      state     <= acq_en ? ST_WAIT_FULL : ST_IDLE;
      beat_cnt  <= '0;
      burst_cnt <= '0;
      addr      <= '0;
      drain_sel <= 1'b0;
      done      <= 1'b0;
    end else begin
      case (state)
        ST_IDLE:      if (acq_en && !done) state <= ST_WAIT_FULL;
        ST_WAIT_FULL: if (bank_full[drain_sel]) state <= ST_REQ_BURST;
        ST_REQ_BURST: if (mem_ready) begin
          state    <= ST_DRAIN;
          beat_cnt <= '0;
        end
        ST_DRAIN: if (mem_ready) begin
          addr     <= addr + 1'b1;
          beat_cnt <= beat_cnt + 1'b1;
          if (beat_cnt == BTW'(DEPTH - 1)) state <= ST_WAIT_EMPTY;
        end
        ST_WAIT_EMPTY: if (bank_empty[drain_sel]) begin
          drain_sel <= ~drain_sel;
          burst_cnt <= burst_cnt + 1'b1;
          if (burst_cnt == CTW'(CAP_BURSTS - 1)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            state <= ST_WAIT_FULL;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_REQ_NEEDS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> bank_full[drain_sel]); // R3
  AST_RETURN_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_WAIT_EMPTY) && !host_clear && !bank_empty[drain_sel]) |=> (state == ST_WAIT_EMPTY)); // R5
endmodule

// File: rtl/pingpong_burst_writer.sv
module pingpong_burst_writer #(
  parameter int DATA_W     = 12,
  parameter int FIFO_DEPTH = 16,
  parameter int CAP_BURSTS = 8,
  parameter int ADDR_W     = 12,
  localparam int BURST_W   = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acq_en,
  input  logic               host_clear,
  input  logic               s_valid,
  input  logic [DATA_W-1:0]  s_data,
  output logic               s_ready,
  output logic               mem_req,
  output logic [BURST_W-1:0] mem_burst,
  output logic               mem_wvalid,
  output logic [DATA_W-1:0]  mem_wdata,
  output logic [ADDR_W-1:0]  mem_addr,
  input  logic               mem_ready,
  output logic               cap_reached,
  output logic               overflow
);
  logic [1:0]        wr_en, rd_en, bank_full, bank_empty, bank_one_left;
  logic [DATA_W-1:0] bank_rdata [2];
  logic              drain_sel, drain_busy, capture_on;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    pbw_bank #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (host_clear),
      .wr_en    (wr_en[b]),
      .wr_data  (s_data),
      .rd_en    (rd_en[b]),
      .rd_data  (bank_rdata[b]),
      .full     (bank_full[b]),
      .empty    (bank_empty[b]),
      .one_left (bank_one_left[b])
    );
  end

  pbw_fill u_fill (
    .clk           (clk),
    .rst_n         (rst_n),
    .flush         (host_clear),
    .s_valid       (s_valid),
    .capture_on    (capture_on),
    .bank_full     (bank_full),
    .bank_one_left (bank_one_left),
    .drain_busy    (drain_busy),
    .drain_sel     (drain_sel),
    .wr_en         (wr_en),
    .s_ready       (s_ready),
    .overflow      (overflow)
  );

  pbw_seq #(.DEPTH(FIFO_DEPTH), .CAP_BURSTS(CAP_BURSTS), .ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .acq_en      (acq_en),
    .host_clear  (host_clear),
    .bank_full   (bank_full),
    .bank_empty  (bank_empty),
    .mem_ready   (mem_ready),
    .mem_req     (mem_req),
    .mem_wvalid  (mem_wvalid),
    .mem_addr    (mem_addr),
    .rd_en       (rd_en),
    .drain_sel   (drain_sel),
    .drain_busy  (drain_busy),
    .capture_on  (capture_on),
    .cap_reached (cap_reached)
  );

  assign mem_burst = BURST_W'(FIFO_DEPTH);
  assign mem_wdata = bank_rdata[drain_sel];

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_req && mem_wvalid)); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n || host_clear)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr))); // R3
  AST_BEAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n || host_clear)
    (mem_wvalid && !mem_ready) |=> (mem_wvalid && $stable(mem_wdata) && $stable(mem_addr))); // R4
  AST_CAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cap_reached |-> (!mem_req && !mem_wvalid && !s_ready)); // R6
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overflow && !host_clear) |=> overflow); // R7
endmodule

// File: tb/pingpong_burst_writer_tb.sv
module pingpong_burst_writer_tb;
  localparam int DW    = 8;
  localparam int DEPTH = 4;
  localparam int CAPB  = 3;
  localparam int AW    = 6;
  localparam int BW    = $clog2(DEPTH + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          acq_en = 1'b0;
  logic          host_clear = 1'b0;
  logic          s_valid = 1'b0;
  logic [DW-1:0] s_data = '0;
  logic          s_ready;
  logic          mem_req;
  logic [BW-1:0] mem_burst;
  logic          mem_wvalid;
  logic [DW-1:0] mem_wdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ready = 1'b1;
  logic          cap_reached;
  logic          overflow;

  int checks = 0;
  int fails  = 0;
  int ready_mode = 1;  // 0: low, 1: high, 2: alternate
  int exp_addr = 0;
  logic [AW+DW-1:0] sb_q[$];
  logic          hold_pend = 1'b0;
  logic [DW-1:0] hold_data;
  logic [AW-1:0] hold_addr;

  always #10 clk = ~clk;

  pingpong_burst_writer #(.DATA_W(DW), .FIFO_DEPTH(DEPTH), .CAP_BURSTS(CAPB), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .acq_en(acq_en), .host_clear(host_clear),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .mem_req(mem_req), .mem_burst(mem_burst), .mem_wvalid(mem_wvalid),
    .mem_wdata(mem_wdata), .mem_addr(mem_addr), .mem_ready(mem_ready),
    .cap_reached(cap_reached), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    #2;
    case (ready_mode)
      0:       mem_ready = 1'b0;
      2:       mem_ready = ~mem_ready;
      default: mem_ready = 1'b1;
    endcase
  end

  // Monitor: compares memory traffic with the scoreboard
  always @(negedge clk) begin
    if (rst_n) begin
      if (hold_pend) begin
        chk(mem_wvalid && mem_wdata == hold_data && mem_addr == hold_addr, "R4 beat hold",
            int'(mem_wdata), int'(hold_data));
      end
      hold_pend = mem_wvalid && !mem_ready && !host_clear;
      hold_data = mem_wdata;
      hold_addr = mem_addr;
      if (mem_req && mem_ready) begin
        chk(int'(mem_burst) == DEPTH, "R3 burst length", int'(mem_burst), DEPTH);
        if (sb_q.size() == 0) chk(1'b0, "R6 unexpected request", 1, 0);
        else chk(mem_addr == sb_q[0][AW+DW-1:DW], "R3 start address",
                 int'(mem_addr), int'(sb_q[0][AW+DW-1:DW]));
      end
      if (mem_wvalid && mem_ready) begin
        if (sb_q.size() == 0) chk(1'b0, "R6 unexpected beat", int'(mem_wdata), -1);
        else begin
          logic [AW+DW-1:0] e;
          e = sb_q.pop_front();
          chk(mem_addr == e[AW+DW-1:DW], "R4 beat address", int'(mem_addr), int'(e[AW+DW-1:DW]));
          chk(mem_wdata == e[DW-1:0], "R2 beat data order", int'(mem_wdata), int'(e[DW-1:0]));
        end
      end
    end
  end

  // Driver: one sample, then gap idle cycles; predicts s_ready and memory placement
  task automatic send(input logic [DW-1:0] d, input bit exp_rdy, input bit stored, input int gap,
                      input string req);
    s_valid = 1'b1;
    s_data  = d;
    #6;
    chk(s_ready == exp_rdy, req, int'(s_ready), int'(exp_rdy));
    if (stored) begin
      sb_q.push_back({AW'(exp_addr), d});
      exp_addr++;
    end
    @(posedge clk); #2;
    s_valid = 1'b0;
    repeat (gap) begin @(posedge clk); #2; end
  endtask

  task automatic cycles(input int n);
    repeat (n) begin @(posedge clk); #2; end
  endtask

  task automatic pulse_clear();
    host_clear = 1'b1;
    cycles(1);
    host_clear = 1'b0;
    exp_addr = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    cycles(3);
    rst_n = 1'b1;
    #6;
    // R1 reset state
    chk(!mem_req && !mem_wvalid, "R1 strobes low", int'(mem_req | mem_wvalid), 0);
    chk(!cap_reached && !overflow, "R1 flags low", int'(cap_reached | overflow), 0);
    chk(mem_addr == 0, "R1 address zero", int'(mem_addr), 0);
    chk(!s_ready, "R1 s_ready low", int'(s_ready), 0);
    cycles(1);

    // R9: disabled, samples ignored
    for (int i = 0; i < 3; i++) send(8'hE0 + 8'(i), 1'b0, 1'b0, 0, "R9 disabled s_ready");
    cycles(2);
    chk(mem_addr == 0 && !overflow && !mem_req, "R9 no effect", int'(mem_addr), 0);
    acq_en = 1'b1;
    cycles(2);

    // R2/R3/R4/R5: first burst, ready always high
    for (int i = 0; i < 4; i++) send(8'h10 + 8'(i), 1'b1, 1'b1, 3, "R2 accept");
    // second burst with ready alternating (beat holding)
    ready_mode = 2;
    for (int i = 0; i < 4; i++) send(8'h20 + 8'(i), 1'b1, 1'b1, 3, "R2 accept");
    cycles(20);
    chk(sb_q.size() == 0, "R5 two bursts written", sb_q.size(), 0);
    chk(mem_addr == 8, "R4 address after two bursts", int'(mem_addr), 8);

    // R7: stall the controller, overfill both banks
    ready_mode = 0;
    cycles(2);
    for (int i = 0; i < 4; i++) send(8'h30 + 8'(i), 1'b1, 1'b1, 0, "R7 bank0 fill");
    for (int i = 0; i < 4; i++) send(8'h40 + 8'(i), 1'b1, 1'b0, 0, "R7 bank1 fill");
    send(8'h50, 1'b0, 1'b0, 0, "R7 both full drop");
    #6;
    chk(overflow, "R7 overflow set", int'(overflow), 1);
    ready_mode = 1;
    cycles(20);
    chk(sb_q.size() == 0, "R6 third burst written", sb_q.size(), 0);
    chk(cap_reached, "R6 capacity reached", int'(cap_reached), 1);
    chk(mem_addr == 12, "R4 final address", int'(mem_addr), 12);
    chk(overflow, "R7 overflow sticky", int'(overflow), 1);
    send(8'h60, 1'b0, 1'b0, 4, "R6 frozen s_ready");

    // R8: clear with acquisition on, full run from zero
    pulse_clear();
    #6;
    chk(!cap_reached && !overflow, "R8 flags cleared", int'(cap_reached | overflow), 0);
    chk(mem_addr == 0, "R8 address rewound", int'(mem_addr), 0);
    cycles(1);
    for (int i = 0; i < 12; i++) send(8'h70 + 8'(i), 1'b1, 1'b1, 3, "R8 accept after clear");
    cycles(20);
    chk(sb_q.size() == 0, "R8 run written", sb_q.size(), 0);
    chk(cap_reached, "R6 capacity after run", int'(cap_reached), 1);
    send(8'h90, 1'b0, 1'b0, 0, "R6 drop at capacity");
    send(8'h91, 1'b0, 1'b0, 2, "R6 drop at capacity");
    chk(!overflow, "R6 no overflow at capacity", int'(overflow), 0);

    // R8 with acquisition off: idle until enabled
    acq_en = 1'b0;
    pulse_clear();
    send(8'hA0, 1'b0, 1'b0, 2, "R9 idle after clear");
    chk(!mem_req && mem_addr == 0, "R8 idle after clear", int'(mem_addr), 0);
    acq_en = 1'b1;
    cycles(2);
    for (int i = 0; i < 4; i++) send(8'hB0 + 8'(i), 1'b1, 1'b1, 3, "R2 accept");
    cycles(20);
    chk(sb_q.size() == 0, "R5 burst after re-enable", sb_q.size(), 0);
    chk(!cap_reached, "R6 not yet at capacity", int'(cap_reached), 0);

    summary();
    $finish;
  end
endmodule